// File: doc/BRIEF.md
# Configuration Address Decoder with Access Filter

This block sits between a configuration-access requester and a memory-mapped configuration window. It takes one request at a time: a target bus number, a device/function number, a register offset, the number of the bus directly upstream of the target, and a read/write flag. It decides whether the access may go ahead. It then returns the byte offset of that register inside the configuration region, or a reject indication. The result comes back on a one-beat response one clock after the request is taken.

The filter uses three inputs that describe the port: the number of the root bus, the link-up status, and a bridge information word. Bits 18:16 of that word give the highest bus number that the region covers. An accepted access gets the standard packed offset. A rejected access yields a zero offset. It also carries a marker telling the completer either to return all-ones read data or to drop the write.

The control is a two-state machine. `IDLE` holds `req_ready` high and waits for a request. The transition `TAKE` (`req_valid` while ready) moves to `RESP`, which presents the registered result for exactly one cycle. The transition `DONE` returns unconditionally to `IDLE`.

Top module: `ecam_cfg_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the next cycle only, and `req_ready` is 0 during that cycle.
- R3: For an allowed access, `rsp_addr` equals bus×2^20 + devfn×2^12 + offset. This places bus at bits 27:20, devfn at bits 19:12 and offset at bits 11:0.
- R4: When `link_up` is 0, an access whose bus differs from `root_bus` is rejected. An access to the root bus is not rejected for this reason.
- R5: An access to the root bus with a devfn other than 0 is rejected.
- R6: An access whose `req_parent` equals `root_bus` and whose devfn is not 0 is rejected.
- R7: An access whose bus number exceeds `brg_info[18:16]` is rejected. A bus number equal to that field is not rejected for this reason.
- R8: An offset whose two low bits are not both 0 is rejected.
- R9: On a rejected response, `rsp_addr` is 0. `rsp_fill_ones` is 1 for a read (`req_write`=0), and `rsp_drop_write` is 1 for a write. On an allowed response, both markers are 0.
- R10: `req_valid` asserted while `req_ready` is 0 is ignored: it produces no response in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 12 | Register byte offset |
| req_parent | input | 8 | Number of the bus upstream of the target |
| root_bus | input | 8 | Root bus number |
| link_up | input | 1 | Link status |
| brg_info | input | 32 | Bridge info word; bits 18:16 give the top bus number |
| rsp_valid | output | 1 | Response beat |
| rsp_addr | output | 28 | Packed configuration offset (0 when rejected) |
| rsp_reject | output | 1 | Access refused |
| rsp_fill_ones | output | 1 | Rejected read: return all-ones data |
| rsp_drop_write | output | 1 | Rejected write: discard it |

## Verification
Allowed accesses use several distinct bus, devfn and offset values. These show that each field lands in its own bit range and that no field overlaps another. Each reject rule is then triggered alone while the others are satisfied, which shows that each rule acts independently. The rules covered are the link-down rule, the root and child devfn rules, the range ceiling and alignment. Each rule also has a near-miss partner that must pass: a root-bus access with the link down, a bus equal to the ceiling, and devfn 0 below the root. Reads and writes are both rejected, to separate the two completion markers, and a request held through the response beat shows that the block takes nothing while busy.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ecam_state_e;

    typedef struct packed {
        logic link_down;
        logic root_fn;
        logic child_fn;
        logic out_of_range;
        logic misaligned;
    } ecam_cause_t;
endpackage

// File: rtl/ecam_filter.sv
module ecam_filter
    import ecam_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFS_W   = 12,
    parameter int LIM_W   = 3,
    parameter int ALIGN_W = 2
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFS_W-1:0]   offset,
    input  logic [BUS_W-1:0]   parent,
    input  logic [BUS_W-1:0]   root,
    input  logic               link_up,
    input  logic [LIM_W-1:0]   limit,
    output ecam_cause_t        cause
);
    localparam int PAD_W = BUS_W - LIM_W;

    logic [BUS_W-1:0] limit_ext;
    logic             on_root;
    logic             fn_nonzero;

    assign limit_ext  = {{PAD_W{1'b0}}, limit};
    assign on_root    = (bus == root);
    assign fn_nonzero = |devfn;

    always_comb begin
        cause.link_down    = !on_root && !link_up;
        cause.root_fn      = on_root && fn_nonzero;
        cause.child_fn     = (parent == root) && fn_nonzero;
        cause.out_of_range = bus > limit_ext;
        cause.misaligned   = |offset[ALIGN_W-1:0];
    end
endmodule

// File: rtl/ecam_addr_pack.sv
module ecam_addr_pack #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFS_W   = 12
) (
    input  logic [BUS_W-1:0]               bus,
    input  logic [DEVFN_W-1:0]             devfn,
    input  logic [OFS_W-1:0]               offset,
    input  logic                           kill,
    output logic [BUS_W+DEVFN_W+OFS_W-1:0] addr
);
    localparam int ADDR_W = BUS_W + DEVFN_W + OFS_W;

    always_comb begin
        if (kill) addr = '0;
        else      addr = {bus, devfn, offset};
    end

    initial begin
        if (ADDR_W != BUS_W + DEVFN_W + OFS_W) $error("address width mismatch");
    end
endmodule

// File: rtl/ecam_cfg_decoder.sv
module ecam_cfg_decoder
    import ecam_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int DEVFN_W   = 8,
    parameter int OFS_W     = 12,
    parameter int INFO_W    = 32,
    parameter int LIM_LSB   = 16,
    parameter int LIM_W     = 3,
    parameter int ADDR_W    = BUS_W + DEVFN_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [BUS_W-1:0]   req_parent,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic               link_up,
    input  logic [INFO_W-1:0]  brg_info,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic               rsp_reject,
    output logic               rsp_fill_ones,
    output logic               rsp_drop_write
);
    ecam_state_e       state_q, state_d;
    ecam_cause_t       cause;
    logic              reject_c;
    logic              take;
    logic [ADDR_W-1:0] addr_c;
    logic [ADDR_W-1:0] addr_q;
    logic              reject_q;
    logic              write_q;
    logic              unused_info_bits;

    assign unused_info_bits = ^brg_info;

    ecam_filter #(
        .BUS_W  (BUS_W),
        .DEVFN_W(DEVFN_W),
        .OFS_W  (OFS_W),
        .LIM_W  (LIM_W),
        .ALIGN_W(2)
    ) u_filter (
        .bus    (req_bus),
        .devfn  (req_devfn),
        .offset (req_offset),
        .parent (req_parent),
        .root   (root_bus),
        .link_up(link_up),
        .limit  (brg_info[LIM_LSB +: LIM_W]),
        .cause  (cause)
    );

    assign reject_c = |cause;

    ecam_addr_pack #(
        .BUS_W  (BUS_W),
        .DEVFN_W(DEVFN_W),
        .OFS_W  (OFS_W)
    ) u_pack (
        .bus   (req_bus),
        .devfn (req_devfn),
        .offset(req_offset),
        .kill  (reject_c),
        .addr  (addr_c)
    );

    assign take = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            reject_q <= 1'b0;
            write_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                addr_q   <= addr_c;
                reject_q <= reject_c;
                write_q  <= req_write;
            end
        end
    end

    always_comb begin
        req_ready      = 1'b0;
        rsp_valid      = 1'b0;
        rsp_addr       = '0;
        rsp_reject     = 1'b0;
        rsp_fill_ones  = 1'b0;
        rsp_drop_write = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                rsp_valid      = 1'b1;
                rsp_addr       = addr_q;
                rsp_reject     = reject_q;
                rsp_fill_ones  = reject_q && !write_q;
                rsp_drop_write = reject_q && write_q;
            end
            default: req_ready = 1'b0;
        endcase
    end

    p_rsp_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));
    p_single_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    p_link_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !link_up && (req_bus != root_bus)) |=> rsp_reject);
    p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_offset[1:0] != 2'b00)) |=> rsp_reject);
    p_reject_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_reject) |-> (rsp_addr == '0) && (rsp_fill_ones != rsp_drop_write));
endmodule

// File: tb/ecam_cfg_decoder_tb.sv
`timescale 1ns/1ps
module ecam_cfg_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_offset = '0;
    logic [7:0]  req_parent = '0;
    logic [7:0]  root_bus = '0;
    logic        link_up = 1'b1;
    logic [31:0] brg_info = 32'h0007_0000;
    logic        rsp_valid;
    logic [27:0] rsp_addr;
    logic        rsp_reject;
    logic        rsp_fill_ones;
    logic        rsp_drop_write;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecam_cfg_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_parent(req_parent), .root_bus(root_bus),
        .link_up(link_up), .brg_info(brg_info), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_reject(rsp_reject), .rsp_fill_ones(rsp_fill_ones),
        .rsp_drop_write(rsp_drop_write)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request, checked one clock after it is taken.
    task automatic access(input string req, input logic wr, input logic [7:0] b,
                          input logic [7:0] fn, input logic [11:0] ofs,
                          input logic [7:0] par, input logic exp_rej);
        logic [27:0] exp_addr;
        exp_addr = exp_rej ? 28'h0 : (28'(b) << 20) + (28'(fn) << 12) + 28'(ofs);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = b; req_devfn = fn;
        req_offset = ofs; req_parent = par;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 valid"}, 32'(rsp_valid), 32'd1);
        check({req, " R2 ready low"}, 32'(req_ready), 32'd0);
        check({req, " reject"}, 32'(rsp_reject), 32'(exp_rej));
        check({req, " addr"}, 32'(rsp_addr), 32'(exp_addr));
        check({req, " R9 fill"}, 32'(rsp_fill_ones), 32'(exp_rej && !wr));
        check({req, " R9 drop"}, 32'(rsp_drop_write), 32'(exp_rej && wr));
        @(negedge clk);
        check({req, " R2 one beat"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_pack;
        root_bus = 8'd0; link_up = 1'b1; brg_info = 32'hA5A7_5A5A;
        access("R3 root fn0", 1'b0, 8'd0, 8'd0, 12'hFFC, 8'd0, 1'b0);
        access("R3 deep bus", 1'b0, 8'd5, 8'hB8, 12'h104, 8'd3, 1'b0);
        access("R3 max fn", 1'b1, 8'd7, 8'hFF, 12'h010, 8'd6, 1'b0);
    endtask

    task automatic t_link;
        root_bus = 8'd2; link_up = 1'b0; brg_info = 32'h0007_0000;
        access("R4 nonroot link down", 1'b0, 8'd3, 8'd0, 12'h000, 8'd2, 1'b1);
        access("R4 root link down ok", 1'b0, 8'd2, 8'd0, 12'h008, 8'd1, 1'b0);
        link_up = 1'b1;
        access("R4 nonroot link up ok", 1'b0, 8'd3, 8'd0, 12'h00C, 8'd2, 1'b0);
    endtask

    task automatic t_devfn;
        root_bus = 8'd1; link_up = 1'b1;
        access("R5 root fn1", 1'b0, 8'd1, 8'd1, 12'h000, 8'd0, 1'b1);
        access("R6 child fn8", 1'b1, 8'd2, 8'd8, 12'h000, 8'd1, 1'b1);
        access("R6 grandchild fn8 ok", 1'b0, 8'd3, 8'd8, 12'h000, 8'd2, 1'b0);
    endtask

    task automatic t_range;
        root_bus = 8'd0; link_up = 1'b1; brg_info = 32'h0003_0000;
        access("R7 bus at limit", 1'b0, 8'd3, 8'd0, 12'h000, 8'd2, 1'b0);
        access("R7 bus over limit", 1'b0, 8'd4, 8'd0, 12'h000, 8'd3, 1'b1);
        brg_info = 32'h0007_0000;
    endtask

    task automatic t_align;
        root_bus = 8'd0;
        access("R8 offset 1", 1'b0, 8'd2, 8'd0, 12'h001, 8'd1, 1'b1);
        access("R8 offset 2 write", 1'b1, 8'd2, 8'd0, 12'h402, 8'd1, 1'b1);
    endtask

    task automatic t_busy;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd2; req_devfn = 8'd0;
        req_offset = 12'h020; req_parent = 8'd1;
        @(negedge clk);
        check("R10 first beat", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        check("R10 held request ignored", 32'(rsp_valid), 32'd0);
        check("R10 ready again", 32'(req_ready), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 no late beat", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_link();
        t_devfn();
        t_range();
        t_align();
        t_busy();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule